// File: doc/BRIEF.md
# Nonvolatile Store/Recall Control Sequencer

This block sits between the four active-low control pins of a shadowed static memory and the memory core. It samples chip enable, write enable, output enable and nonvolatile enable through a two-flop synchroniser. It decodes the sampled pins into idle, read, write, store and recall modes. Reads and writes pass straight to the core as level commands.

A store copies the array into the nonvolatile cells. A recall copies it back. Either one starts only when the pins move into the qualifying combination. Once started, it runs on its own for a parameterised number of clocks and waits for the core to report completion. While it runs, the data outputs are held in high impedance and the pins are ignored. A supply-good input gates stores and aborts a store that is in progress. The first rise of supply-good after reset launches an automatic recall, and the block refuses normal accesses until that recall completes.

Top module: `nv_seq_ctrl`

## Requirements
- R1: The pins decode as follows, all active low. Chip enable high gives no command. Chip enable low with nonvolatile enable high and write enable low gives `core_wr_o` with `dq_oe_o` low. Chip enable low, nonvolatile enable high, write enable high and output enable low give `core_rd_o` with `dq_oe_o` high.
- R2: A store (`core_store_o` and `busy_o` high) starts when the pins move into chip enable low, write enable low, output enable high and nonvolatile enable low, provided supply-good is high.
- R3: A recall (`core_recall_o` and `busy_o` high) starts when the pins move into chip enable low, output enable low, nonvolatile enable low and write enable high.
- R4: A nonvolatile cycle starts only on entry into its pin combination. If the pins are still in that combination when a cycle ends, no new cycle starts until a pin leaves the combination and returns.
- R5: With `core_done_i` held high, a store lasts exactly STORE_CYCLES clocks and a recall exactly RECALL_CYCLES clocks. If `core_done_i` is low when the count expires, the cycle is extended until `core_done_i` is seen.
- R6: While a cycle runs, pin changes have no effect: `dq_oe_o`, `core_rd_o` and `core_wr_o` stay low.
- R7: No store starts while supply-good is low. A store combination held while supply-good returns does not start a store.
- R8: If supply-good falls during a store, the store is abandoned and `store_abort_o` is set. The flag stays set until a later store completes.
- R9: After reset `busy_o` is high and reads and writes are refused. The first rise of supply-good starts a recall, and normal access begins when that recall ends. Later rises of supply-good start nothing.
- R10: A read combination present on the pins when a cycle ends takes effect in the first clock after `busy_o` falls, with `dq_oe_o` high.
- R11: If write enable is already low when chip enable falls, `dq_oe_o` stays low for that whole chip selection, even after the pins change to a read.
- R12: Reset leaves every core command low, `dq_oe_o` low and `store_abort_o` low.
- R13: At most one of the four core commands is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable pin, active low |
| we_ni | input | 1 | Write enable pin, active low |
| oe_ni | input | 1 | Output enable pin, active low |
| nve_ni | input | 1 | Nonvolatile enable pin, active low |
| pwr_ok_i | input | 1 | Digital supply-good indication |
| core_done_i | input | 1 | Core reports the nonvolatile transfer has finished |
| core_rd_o | output | 1 | Read command to the core |
| core_wr_o | output | 1 | Write command to the core |
| core_store_o | output | 1 | Store in progress to the core |
| core_recall_o | output | 1 | Recall in progress to the core |
| dq_oe_o | output | 1 | Data output driver enable |
| busy_o | output | 1 | Nonvolatile cycle or power-up wait in progress |
| store_abort_o | output | 1 | Last store was abandoned on supply loss |

## Verification
The assertions check on every cycle that the core commands are mutually exclusive and that busy or writing keeps the outputs off. They also check that a store never begins or survives without supply-good, and that the abort flag rises only out of a running store. Only the bench scenarios can show the behaviours that depend on pin history: triggering on edges rather than levels, the exact cycle lengths and their extension by the done handshake, the single power-up recall, the read taking effect at the end of a cycle, and the write-first output lock.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_READ,
    MD_WRITE,
    MD_STORE,
    MD_RECALL
  } nvs_mode_e;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_READY,
    ST_STORE,
    ST_RECALL
  } nvs_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic nve_n;
  } nvs_pins_t;

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nvs_decode.sv
module nvs_decode
  import nvs_pkg::*;
(
  input  nvs_pins_t pins_i,
  output nvs_mode_e mode_o
);

  always_comb begin
    mode_o = MD_IDLE;
    if (!pins_i.ce_n) begin
      if (pins_i.nve_n) begin
        if (!pins_i.we_n)      mode_o = MD_WRITE;
        else if (!pins_i.oe_n) mode_o = MD_READ;
      end else begin
        if (!pins_i.we_n && pins_i.oe_n)      mode_o = MD_STORE;
        else if (pins_i.we_n && !pins_i.oe_n) mode_o = MD_RECALL;
      end
    end
  end

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned STORE_CYCLES  = 40,
  parameter int unsigned RECALL_CYCLES = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  input  logic nve_ni,
  input  logic pwr_ok_i,
  input  logic core_done_i,
  output logic core_rd_o,
  output logic core_wr_o,
  output logic core_store_o,
  output logic core_recall_o,
  output logic dq_oe_o,
  output logic busy_o,
  output logic store_abort_o
);

  localparam int unsigned MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] STORE_LOAD  = CNT_W'(STORE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECALL_LOAD = CNT_W'(RECALL_CYCLES - 1);

  logic [3:0] pins_raw;
  nvs_pins_t  pins_s;
  logic       pwr_s;
  nvs_mode_e  mode_d, mode_q;
  nvs_state_e state_q, state_d;
  logic       tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic       done_seen_q, cyc_done, in_cycle;
  logic       abort_q, abort_set, abort_clr;
  logic       ce_prev_q, lock_q;
  logic       store_req, recall_req;

  nvs_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_ni, we_ni, oe_ni, nve_ni}),
    .q_o   (pins_raw)
  );
  assign pins_s = nvs_pins_t'(pins_raw);

  nvs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_ok_i),
    .q_o   (pwr_s)
  );

  nvs_decode u_decode (
    .pins_i(pins_s),
    .mode_o(mode_d)
  );

  nvs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .run_i     (in_cycle),
    .zero_o    (tmr_zero)
  );

  // entry into a qualifying combination, judged against the previous decode
  assign store_req  = (mode_d == MD_STORE)  && (mode_q != MD_STORE);
  assign recall_req = (mode_d == MD_RECALL) && (mode_q != MD_RECALL);
  assign in_cycle   = (state_q == ST_STORE) || (state_q == ST_RECALL);
  assign cyc_done   = tmr_zero && (done_seen_q || core_done_i);

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = RECALL_LOAD;
    abort_set = 1'b0;
    abort_clr = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        if (pwr_s) begin
          state_d  = ST_RECALL;
          tmr_load = 1'b1;
        end
      end
      ST_READY: begin
        if (store_req && pwr_s) begin
          state_d  = ST_STORE;
          tmr_load = 1'b1;
          tmr_val  = STORE_LOAD;
        end else if (recall_req) begin
          state_d  = ST_RECALL;
          tmr_load = 1'b1;
        end
      end
      ST_STORE: begin
        if (!pwr_s) begin
          state_d   = ST_READY;
          abort_set = 1'b1;
        end else if (cyc_done) begin
          state_d   = ST_READY;
          abort_clr = 1'b1;
        end
      end
      ST_RECALL: begin
        if (cyc_done) state_d = ST_READY;
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_INIT;
      mode_q      <= MD_IDLE;
      done_seen_q <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      if (tmr_load)                   done_seen_q <= 1'b0;
      else if (in_cycle && core_done_i) done_seen_q <= 1'b1;
      if (abort_set)      abort_q <= 1'b1;
      else if (abort_clr) abort_q <= 1'b0;
    end
  end

  // write-first selection keeps the drivers off until chip enable rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_prev_q <= 1'b1;
      lock_q    <= 1'b0;
    end else begin
      ce_prev_q <= pins_s.ce_n;
      if (pins_s.ce_n)                          lock_q <= 1'b0;
      else if (ce_prev_q && !pins_s.we_n)       lock_q <= 1'b1;
    end
  end

  assign core_rd_o     = (state_q == ST_READY) && (mode_d == MD_READ);
  assign core_wr_o     = (state_q == ST_READY) && (mode_d == MD_WRITE);
  assign core_store_o  = (state_q == ST_STORE);
  assign core_recall_o = (state_q == ST_RECALL);
  assign dq_oe_o       = core_rd_o && !lock_q;
  assign busy_o        = (state_q != ST_READY);
  assign store_abort_o = abort_q;

endmodule

// File: rtl/nv_seq_ctrl_chk.sv
module nv_seq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic core_rd_o,
  input logic core_wr_o,
  input logic core_store_o,
  input logic core_recall_o,
  input logic dq_oe_o,
  input logic busy_o,
  input logic store_abort_o,
  input logic pwr_s
);

  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_rd_o, core_wr_o, core_store_o, core_recall_o})); // R13

  AST_BUSY_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !dq_oe_o); // R6

  AST_BUSY_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(core_rd_o || core_wr_o)); // R9

  AST_WRITE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_o |-> !dq_oe_o); // R1

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> core_rd_o); // R1

  AST_STORE_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_store_o && !pwr_s) |=> !core_store_o); // R7

  AST_STORE_ABANDON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_store_o && !pwr_s) |=> (!core_store_o && store_abort_o)); // R8

  AST_ABORT_FROM_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(store_abort_o) |-> $past(core_store_o)); // R8

endmodule

bind nv_seq_ctrl nv_seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .core_rd_o    (core_rd_o),
  .core_wr_o    (core_wr_o),
  .core_store_o (core_store_o),
  .core_recall_o(core_recall_o),
  .dq_oe_o      (dq_oe_o),
  .busy_o       (busy_o),
  .store_abort_o(store_abort_o),
  .pwr_s        (pwr_s)
);

// File: tb/nv_seq_ctrl_tb_top.sv
module nv_seq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ST_CYC = 40;
  localparam int RC_CYC = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, nve_ni = 1'b1;
  logic pwr_ok_i = 1'b0;
  logic core_done_i = 1'b1;
  logic core_rd_o, core_wr_o, core_store_o, core_recall_o, dq_oe_o, busy_o, store_abort_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nv_seq_ctrl #(.STORE_CYCLES(ST_CYC), .RECALL_CYCLES(RC_CYC), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni), .nve_ni(nve_ni),
    .pwr_ok_i(pwr_ok_i), .core_done_i(core_done_i),
    .core_rd_o(core_rd_o), .core_wr_o(core_wr_o),
    .core_store_o(core_store_o), .core_recall_o(core_recall_o),
    .dq_oe_o(dq_oe_o), .busy_o(busy_o), .store_abort_o(store_abort_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pins(input logic ce, input logic we, input logic oe, input logic nve);
    ce_ni = ce; we_ni = we; oe_ni = oe; nve_ni = nve;
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? core_store_o : core_recall_o;
  endfunction

  // waits for the selected cycle to begin and counts its clocks
  task automatic measure(input int sel, output int n);
    int g = 0;
    n = 0;
    while (!pick(sel) && g < 200) begin @(negedge clk_i); g++; end
    while (pick(sel) && n < 100000) begin n++; @(negedge clk_i); end
  endtask

  task automatic store_w_ctrl();
    pins(1'b0, 1'b1, 1'b1, 1'b0);
    step(3);
    we_ni = 1'b0;
  endtask

  task automatic t_reset();
    pins(1'b0, 1'b1, 1'b0, 1'b1);
    step(1);
    rst_ni = 1'b1;
    step(4);
    chk("R12", "rd", core_rd_o, 0);
    chk("R12", "store", core_store_o, 0);
    chk("R12", "recall", core_recall_o, 0);
    chk("R12", "dq_oe", dq_oe_o, 0);
    chk("R12", "abort", store_abort_o, 0);
    chk("R9", "busy before power", busy_o, 1);
  endtask

  task automatic t_powerup();
    int n;
    pwr_ok_i = 1'b1;
    measure(1, n);
    chk("R9", "auto recall length", n, RC_CYC);
    chk("R10", "busy after recall", busy_o, 0);
    chk("R10", "dq_oe after recall", dq_oe_o, 1);
    chk("R10", "rd after recall", core_rd_o, 1);
  endtask

  task automatic t_rw();
    pins(1'b0, 1'b0, 1'b0, 1'b1);
    step(3);
    chk("R1", "write cmd", core_wr_o, 1);
    chk("R1", "write dq_oe", dq_oe_o, 0);
    pins(1'b0, 1'b1, 1'b0, 1'b1);
    step(3);
    chk("R1", "read cmd", core_rd_o, 1);
    chk("R1", "read dq_oe", dq_oe_o, 1);
    pins(1'b1, 1'b1, 1'b0, 1'b1);
    step(3);
    chk("R1", "deselect rd", core_rd_o, 0);
    chk("R1", "deselect wr", core_wr_o, 0);
  endtask

  task automatic t_lock();
    pins(1'b0, 1'b0, 1'b0, 1'b1);
    step(3);
    we_ni = 1'b1;
    step(3);
    chk("R11", "rd under lock", core_rd_o, 1);
    chk("R11", "dq_oe under lock", dq_oe_o, 0);
    ce_ni = 1'b1;
    step(3);
    ce_ni = 1'b0;
    step(3);
    chk("R11", "dq_oe after reselect", dq_oe_o, 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
  endtask

  task automatic t_store();
    int n;
    store_w_ctrl();
    measure(0, n);
    chk("R2", "store seen", (n > 0) ? 1 : 0, 1);
    chk("R5", "store length", n, ST_CYC);
    step(10);
    chk("R4", "no retrigger store", core_store_o, 0);
    chk("R4", "no retrigger busy", busy_o, 0);
    oe_ni = 1'b0;
    step(3);
    oe_ni = 1'b1;
    step(3);
    chk("R4", "store after re-entry", core_store_o, 1);
    while (busy_o) @(negedge clk_i);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
  endtask

  task automatic t_ignore();
    store_w_ctrl();
    step(5);
    chk("R6", "store running", core_store_o, 1);
    pins(1'b0, 1'b1, 1'b0, 1'b1);
    step(3);
    chk("R6", "rd ignored", core_rd_o, 0);
    chk("R6", "dq_oe off", dq_oe_o, 0);
    chk("R6", "still storing", core_store_o, 1);
    while (busy_o) @(negedge clk_i);
    chk("R10", "dq_oe at end", dq_oe_o, 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
  endtask

  task automatic t_recall();
    int n;
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    measure(1, n);
    chk("R3", "recall length", n, RC_CYC);
    step(10);
    chk("R4", "no retrigger recall", core_recall_o, 0);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
  endtask

  task automatic t_done_wait();
    core_done_i = 1'b0;
    store_w_ctrl();
    step(ST_CYC + 10);
    chk("R5", "held without done", busy_o, 1);
    core_done_i = 1'b1;
    @(negedge clk_i);
    core_done_i = 1'b0;
    step(1);
    chk("R5", "ends on done", busy_o, 0);
    core_done_i = 1'b1;
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
  endtask

  task automatic t_pwr_block();
    pwr_ok_i = 1'b0;
    step(3);
    store_w_ctrl();
    step(5);
    chk("R7", "store blocked", core_store_o, 0);
    chk("R7", "busy blocked", busy_o, 0);
    pwr_ok_i = 1'b1;
    step(5);
    chk("R7", "no start on power return", core_store_o, 0);
    chk("R9", "no second auto recall", core_recall_o, 0);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
  endtask

  task automatic t_abort();
    int n;
    store_w_ctrl();
    step(5);
    chk("R8", "store running", core_store_o, 1);
    pwr_ok_i = 1'b0;
    step(3);
    chk("R8", "store dropped", core_store_o, 0);
    chk("R8", "abort flag", store_abort_o, 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    pwr_ok_i = 1'b1;
    step(5);
    chk("R9", "no recall on re-rise", busy_o, 0);
    chk("R8", "abort held", store_abort_o, 1);
    store_w_ctrl();
    measure(0, n);
    chk("R8", "clean store length", n, ST_CYC);
    chk("R8", "abort cleared", store_abort_o, 0);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(2);
    t_reset();
    t_powerup();
    t_rw();
    t_lock();
    t_store();
    t_ignore();
    t_recall();
    t_done_wait();
    t_pwr_block();
    t_abort();
    finish_run();
  end

endmodule